// File: doc/BRIEF.md
# Fuse Macro Read Sequencer

This block reads a one-time-programmable fuse array one byte per access. Software first loads a start cycle and an active length for each of the five macro controls (select, program enable, load, address enable and strobe). It then clears the user-mode bit and writes a single command word that carries a 10-bit fuse address. The block counts clock cycles from the start of the access and drives each macro control inside its own window. It latches the macro's output byte at the end of the strobe window and sets a sticky finish flag, which software clears by writing a one to it.

A second set of windows for the program sequence is held in registers so that software can read it back, but no read uses it. All configuration and status go through a plain 32-bit register port with byte offsets. Register writes take effect on the clock edge. Reads are combinational from the offset.

Top module: `efuse_rd_seq`

## Requirements
- R1: After reset the mode register (0x00) reads 1, the status register (0x18) reads 0, every window register reads 0, the select and program-enable outputs are high, and load, address enable and strobe are low.
- R2: A window register keeps its start cycle in bits [31:16] and its length in bits [15:0]. The read windows sit at 0x3C, 0x40, 0x44, 0x48 and 0x4C, for select, program enable, load, address enable and strobe in that order. The program windows sit at 0x28 to 0x38 in the same order and read back as written, with no effect on a read access.
- R3: A write to 0x24 with bits [1:0] both 1 starts an access when mode bit 0 is 0 and no access is busy. Any other value in bits [1:0] starts nothing. The address in bits [25:16] is latched, reads back in the same field, and drives fuse_addr_o.
- R4: Cycle k = 0 is the first cycle after the accepted command write. Each control is asserted exactly in the cycles start <= k < start+length, and a control with length 0 is never asserted. Select and program enable are asserted low. Load, address enable and strobe are asserted high.
- R5: The byte on fuse_dout_i in the last cycle of the strobe window is stored and reads back at 0x20 bits [7:0]. If the strobe length is 0, the stored byte keeps its old value.
- R6: Status bit 1 (busy) is 1 from cycle 0 through cycle E. E is the largest start+length among read windows with a nonzero length, or 0 if every length is 0. Status bit 0 (finish) is 1 from cycle E+1.
- R7: Writing 1 to status bit 0 clears the finish flag. Writing 0 leaves it unchanged.
- R8: A command written while busy, or while mode bit 0 is 1, changes neither the latched address nor the outputs, and starts no access.
- R9: Offset 0x50 reads the REV_ID parameter.
- R10: While no access is busy, every macro control sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| fuse_sel_no | output | 1 | Macro select, active low |
| fuse_pgm_no | output | 1 | Macro program enable, active low |
| fuse_load_o | output | 1 | Macro load |
| fuse_aen_o | output | 1 | Macro address enable |
| fuse_strb_o | output | 1 | Macro strobe |
| fuse_addr_o | output | 10 | Latched fuse address |
| fuse_dout_i | input | 8 | Byte returned by the macro |

## Verification
The hardest case to reach is a command that arrives in the middle of a running access. It must neither restart the counter nor replace the latched address. To cover it, the bench checks every cycle of the typical read and, in cycle 10, writes a second command with a different address. The bench then confirms that all windows, the end cycle, the captured byte and the address readback still belong to the first command. Separate accesses cover the active-low polarity, zero-length windows and an access in which every length is zero. In that last access the finish flag must rise one cycle after start.

// File: rtl/efuse_seq_pkg.sv
package efuse_seq_pkg;
  localparam int TW   = 16;
  localparam int CW   = TW + 1;
  localparam int FAW  = 10;
  localparam int NWIN = 5;

  // window index order matches the register order
  localparam int W_SEL  = 0;
  localparam int W_PGM  = 1;
  localparam int W_LOAD = 2;
  localparam int W_AEN  = 3;
  localparam int W_STRB = 4;

  typedef struct packed {
    logic [TW-1:0] start;
    logic [TW-1:0] len;
  } win_t;

  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_CMD  = 8'h24;
  localparam logic [7:0] OFS_PWIN = 8'h28;
  localparam logic [7:0] OFS_RWIN = 8'h3C;
  localparam logic [7:0] OFS_REV  = 8'h50;
endpackage

// File: rtl/efuse_win_gen.sv
module efuse_win_gen
  import efuse_seq_pkg::*;
(
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  input  win_t          win_i,
  output logic          act_o,
  output logic          last_o
);
  logic [CW-1:0] stop;

  assign stop   = CW'(win_i.start) + CW'(win_i.len);
  assign act_o  = busy_i && (cnt_i >= CW'(win_i.start)) && (cnt_i < stop);
  assign last_o = busy_i && (win_i.len != '0) && (cnt_i == stop - CW'(1));
endmodule

// File: rtl/efuse_seq_ctrl.sv
module efuse_seq_ctrl
  import efuse_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  win_t [NWIN-1:0]  rwin_i,
  output logic [NWIN-1:0]  act_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cap_o
);
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   end_c;
  logic [NWIN-1:0] last;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    efuse_win_gen i_win (
      .busy_i (busy_o),
      .cnt_i  (cnt_q),
      .win_i  (rwin_i[i]),
      .act_o  (act_o[i]),
      .last_o (last[i])
    );
  end

  // end cycle: latest close among non-empty windows
  always_comb begin
    end_c = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (rwin_i[i].len != '0 &&
          (CW'(rwin_i[i].start) + CW'(rwin_i[i].len)) > end_c)
        end_c = CW'(rwin_i[i].start) + CW'(rwin_i[i].len);
    end
  end

  assign done_o = busy_o && (cnt_q == end_c);
  assign cap_o  = last[W_STRB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (done_o) busy_o <= 1'b0;
      else        cnt_q  <= cnt_q + CW'(1);
    end
  end

  a_r6_count_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !start_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/efuse_seq_regs.sv
module efuse_seq_regs
  import efuse_seq_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h0000_0102
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             cap_i,
  input  logic [7:0]       fuse_dout_i,
  output win_t [NWIN-1:0]  rwin_o,
  output logic             start_o,
  output logic             mode_o,
  output logic             flag_o,
  output logic [7:0]       data_o,
  output logic [FAW-1:0]   faddr_o
);
  logic wr;
  win_t pwin_q [NWIN];
  win_t rwin_q [NWIN];

  assign wr      = bus_req_i && bus_we_i;
  assign start_o = wr && (bus_addr_i == OFS_CMD) && (bus_wdata_i[1:0] == 2'b11)
                   && !mode_o && !busy_i;

  for (genvar i = 0; i < NWIN; i++) begin : g_wreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pwin_q[i] <= '0;
        rwin_q[i] <= '0;
      end else if (wr) begin
        if (bus_addr_i == OFS_PWIN + 8'(4*i)) pwin_q[i] <= bus_wdata_i;
        if (bus_addr_i == OFS_RWIN + 8'(4*i)) rwin_q[i] <= bus_wdata_i;
      end
    end
    assign rwin_o[i] = rwin_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= 1'b1;
      flag_o  <= 1'b0;
      data_o  <= '0;
      faddr_o <= '0;
    end else begin
      if (wr && bus_addr_i == OFS_MODE) mode_o <= bus_wdata_i[0];
      if (start_o) faddr_o <= bus_wdata_i[16 +: FAW];
      if (cap_i)   data_o  <= fuse_dout_i;
      // set wins over a same-cycle clear
      if (done_i) flag_o <= 1'b1;
      else if (wr && bus_addr_i == OFS_STAT && bus_wdata_i[0]) flag_o <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_MODE: bus_rdata_o = {31'b0, mode_o};
      OFS_STAT: bus_rdata_o = {30'b0, busy_i, flag_o};
      OFS_DATA: bus_rdata_o = {24'b0, data_o};
      OFS_CMD:  bus_rdata_o = {6'b0, faddr_o, 16'b0};
      OFS_REV:  bus_rdata_o = REV_ID;
      default:  bus_rdata_o = '0;
    endcase
    for (int i = 0; i < NWIN; i++) begin
      if (bus_addr_i == OFS_PWIN + 8'(4*i)) bus_rdata_o = pwin_q[i];
      if (bus_addr_i == OFS_RWIN + 8'(4*i)) bus_rdata_o = rwin_q[i];
    end
  end

  a_r5_data_only_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(data_o));
  a_r7_flag_rises_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(done_i));
endmodule

// File: rtl/efuse_rd_seq.sv
module efuse_rd_seq
  import efuse_seq_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h0000_0102
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             fuse_sel_no,
  output logic             fuse_pgm_no,
  output logic             fuse_load_o,
  output logic             fuse_aen_o,
  output logic             fuse_strb_o,
  output logic [FAW-1:0]   fuse_addr_o,
  input  logic [7:0]       fuse_dout_i
);
  win_t [NWIN-1:0] rwin;
  logic [NWIN-1:0] act;
  logic start, busy, done, cap, mode, flag;
  logic [7:0] data;

  efuse_seq_regs #(.REV_ID(REV_ID)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy),
    .done_i      (done),
    .cap_i       (cap),
    .fuse_dout_i (fuse_dout_i),
    .rwin_o      (rwin),
    .start_o     (start),
    .mode_o      (mode),
    .flag_o      (flag),
    .data_o      (data),
    .faddr_o     (fuse_addr_o)
  );

  efuse_seq_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .rwin_i  (rwin),
    .act_o   (act),
    .busy_o  (busy),
    .done_o  (done),
    .cap_o   (cap)
  );

  assign fuse_sel_no = ~act[W_SEL];
  assign fuse_pgm_no = ~act[W_PGM];
  assign fuse_load_o = act[W_LOAD];
  assign fuse_aen_o  = act[W_AEN];
  assign fuse_strb_o = act[W_STRB];

  a_r8_user_mode_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode && !busy) |=> !busy);
  a_r8_start_needs_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(!mode));
  a_r8_addr_held_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(fuse_addr_o));
  a_r6_finish_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> flag);
  a_r10_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (fuse_sel_no && fuse_pgm_no && !fuse_load_o && !fuse_aen_o && !fuse_strb_o));
  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(data));
endmodule

// File: tb/test_efuse_rd_seq.sv
`timescale 1ns/1ps
module test_efuse_rd_seq;
  localparam logic [31:0] REV = 32'h0000_0102;
  localparam logic [7:0] A_MODE = 8'h00, A_STAT = 8'h18, A_DATA = 8'h20,
                         A_CMD = 8'h24, A_PWIN = 8'h28, A_RWIN = 8'h3C, A_REV = 8'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sel_n, pgm_n, load, aen, strb;
  logic [9:0] faddr;
  logic [7:0] fdout;
  int checks = 0, errors = 0;
  int ws[5], wl[5];

  always #2.5 clk = ~clk;

  efuse_rd_seq #(.REV_ID(REV)) i_efuse_rd_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fuse_sel_no(sel_n), .fuse_pgm_no(pgm_n), .fuse_load_o(load),
    .fuse_aen_o(aen), .fuse_strb_o(strb), .fuse_addr_o(faddr),
    .fuse_dout_i(fdout));

  function automatic logic [7:0] fuse_byte(input logic [5:0] a);
    return (8'(a) * 8'd29) ^ 8'h5A;
  endfunction

  assign fdout = strb ? fuse_byte(faddr[5:0]) : 8'h00;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  function automatic bit on(input int w, input int k);
    return (wl[w] != 0) && (k >= ws[w]) && (k < ws[w] + wl[w]);
  endfunction

  task automatic set_rwin(input int w, input int s, input int l);
    ws[w] = s; wl[w] = l;
    bus_wr(A_RWIN + 8'(4*w), {16'(s), 16'(l)});
  endtask

  // runs one access, checking every cycle; inj_k >= 0 injects a second command
  task automatic run_access(input logic [9:0] fa, input int inj_k,
                            input logic [9:0] inj_a, input logic [7:0] exp_d);
    int e = 0;
    logic [31:0] st;
    for (int w = 0; w < 5; w++)
      if (wl[w] != 0 && ws[w] + wl[w] > e) e = ws[w] + wl[w];
    bus_wr(A_STAT, 32'h1);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = A_CMD; wdata = {6'b0, fa, 14'b0, 2'b11};
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
    for (int k = 0; k <= e + 1; k++) begin
      @(negedge clk);
      if (k == inj_k + 1) begin req = 1'b0; we = 1'b0; end
      addr = A_STAT; #1;
      st = rdata;
      chk(st[1] == (k <= e), "R6 busy", {31'b0, st[1]}, {31'b0, k <= e});
      chk(st[0] == (k > e), "R6 finish", {31'b0, st[0]}, {31'b0, k > e});
      chk(sel_n == !on(0, k), "R4 select", {31'b0, sel_n}, {31'b0, !on(0, k)});
      chk(pgm_n == !on(1, k), "R4 program enable", {31'b0, pgm_n}, {31'b0, !on(1, k)});
      chk(load == on(2, k), "R4 load", {31'b0, load}, {31'b0, on(2, k)});
      chk(aen == on(3, k), "R4 address enable", {31'b0, aen}, {31'b0, on(3, k)});
      chk(strb == on(4, k), "R4 strobe", {31'b0, strb}, {31'b0, on(4, k)});
      if (k == 0) chk(faddr == fa, "R3 fuse address", {22'b0, faddr}, {22'b0, fa});
      if (k == inj_k) begin
        req = 1'b1; we = 1'b1; addr = A_CMD; wdata = {6'b0, inj_a, 14'b0, 2'b11};
      end
    end
    bus_rd(A_DATA, st);
    chk(st == {24'b0, exp_d}, "R5 data", st, {24'b0, exp_d});
    bus_rd(A_CMD, st);
    chk(st == {6'b0, fa, 16'b0}, "R3 R8 address readback", st, {6'b0, fa, 16'b0});
    chk(faddr == fa, "R8 fuse address kept", {22'b0, faddr}, {22'b0, fa});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(A_MODE, d); chk(d == 32'h1, "R1 mode", d, 32'h1);
    bus_rd(A_STAT, d); chk(d == 32'h0, "R1 status", d, 32'h0);
    for (int w = 0; w < 5; w++) begin
      bus_rd(A_RWIN + 8'(4*w), d); chk(d == 32'h0, "R1 read window", d, 32'h0);
      bus_rd(A_PWIN + 8'(4*w), d); chk(d == 32'h0, "R1 program window", d, 32'h0);
    end
    chk({sel_n, pgm_n, load, aen, strb} == 5'b11000, "R1 R10 idle outputs",
        {27'b0, sel_n, pgm_n, load, aen, strb}, 32'h18);
    bus_rd(A_REV, d); chk(d == REV, "R9 revision", d, REV);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    for (int w = 0; w < 5; w++) begin
      bus_wr(A_PWIN + 8'(4*w), {16'(3 + w), 16'(40 + w)});
      bus_rd(A_PWIN + 8'(4*w), d);
      chk(d == {16'(3 + w), 16'(40 + w)}, "R2 program window readback", d, {16'(3 + w), 16'(40 + w)});
    end
    set_rwin(0, 0, 0); set_rwin(1, 0, 0); set_rwin(2, 15, 50);
    set_rwin(3, 24, 31); set_rwin(4, 27, 37);
    bus_rd(A_RWIN + 8'h10, d);
    chk(d == {16'd27, 16'd37}, "R2 strobe window fields", d, {16'd27, 16'd37});
  endtask

  task automatic t_user_mode;
    logic [31:0] d;
    bus_wr(A_CMD, {6'b0, 10'h011, 14'b0, 2'b11});
    repeat (3) @(negedge clk);
    bus_rd(A_STAT, d); chk(d == 32'h0, "R8 user mode blocks start", d, 32'h0);
    bus_rd(A_CMD, d); chk(d == 32'h0, "R8 user mode keeps address", d, 32'h0);
    chk(load == 1'b0, "R8 R10 no load in user mode", {31'b0, load}, 32'h0);
    bus_wr(A_MODE, 32'h0);
    bus_wr(A_CMD, {6'b0, 10'h012, 14'b0, 2'b01});
    repeat (2) @(negedge clk);
    bus_rd(A_STAT, d); chk(d == 32'h0, "R3 partial command ignored", d, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, d); chk(d == 32'h1, "R7 write zero keeps flag", d, 32'h1);
    bus_wr(A_STAT, 32'h1);
    bus_rd(A_STAT, d); chk(d == 32'h0, "R7 write one clears flag", d, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_user_mode();
    // typical timings, second command injected mid-access
    run_access(10'h025, 10, 10'h003, fuse_byte(6'h25));
    t_w1c();
    // active-low windows, zero-length load
    set_rwin(0, 2, 3); set_rwin(1, 0, 1); set_rwin(2, 9, 0);
    set_rwin(3, 5, 2); set_rwin(4, 4, 4);
    run_access(10'h03F, -1, 10'h0, fuse_byte(6'h3F));
    // every length zero: no controls, finish right after cycle 0, data kept
    for (int w = 0; w < 5; w++) set_rwin(w, 7 + w, 0);
    run_access(10'h001, -1, 10'h0, fuse_byte(6'h3F));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule